// File: doc/BRIEF.md
# Serial Flash Status Register and Write Protection

This block keeps the status byte of a serial NOR flash and decides what may be written. It holds the write-enable latch and the six nonvolatile protection bits: a hardware-protect enable bit and a five-bit protection-level field. It tells the program/erase controller whether the address under test falls in a locked region. It also tells the command decoder whether a status-register write may proceed.

The command decoder delivers one-cycle strobes for write enable, write disable and status write. A status write arrives with its data byte while the chip select is low. The block holds it as pending and commits it when chip select rises. If the write-protect pin falls while chip select is still low, the pending write is dropped. The program/erase controller drives a busy level and a one-cycle completion pulse. While busy is high, the status byte reads as all ones, and the enable, disable and status-write strobes are ignored. The protection bits are kept in ordinary flops that reset to zero.

Top module: `flash_wp_status`

## Requirements
- R1: After reset the status byte is 00h and `sr_write_ok` is 0.
- R2: Status byte layout: bit 7 is the hardware-protect enable, bits 6..2 are level bits L4..L0 (bit 6 = L4, bit 2 = L0), bit 1 is the write-enable latch and bit 0 is busy. A write-enable strobe sets bit 1.
- R3: A write-disable strobe clears the write-enable latch, whatever the level of `wp_n`.
- R4: A committed status write loads bits 7..2 from the data byte. Data bits 1..0 are ignored.
- R5: While `busy` is high, the status byte reads FFh.
- R6: A `cycle_done` pulse clears the write-enable latch.
- R7: With L2..L0 = 000, L4:L3 locks nothing (00), 07E000h–07FFFFh (01), 07C000h–07FFFFh (10) or 078000h–07FFFFh (11). L4:L3 are ignored when L2..L0 is nonzero.
- R8: L2..L0 = 001 locks 070000h–07FFFFh, 010 locks 060000h–07FFFFh and 011 locks 040000h–07FFFFh. L2 = 1 locks the whole array.
- R9: When `wp_n` is 0 and the protect enable is 1, `sr_write_ok` is 0 and a status write leaves bits 7..2 unchanged, so the enable cannot be cleared.
- R10: With the protect enable at 0, a low `wp_n` has no effect, and `sr_write_ok` follows the write-enable latch.
- R11: If `wp_n` falls while chip select is still low after the status data, the pending write is dropped. If `wp_n` falls after chip select has risen, the committed write stands.
- R12: With the write-enable latch at 0, `sr_write_ok` is 0 and a status write has no effect.
- R13: Enable, disable and status-write strobes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select level, low while a frame is open |
| wp_n | input | 1 | Write-protect pin level, low requests protection |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| wrsr_stb | input | 1 | Status-write data strobe |
| wrsr_data | input | 8 | Status-write data byte |
| busy | input | 1 | Program/erase/status cycle in progress |
| cycle_done | input | 1 | One-cycle pulse at the end of an internal cycle |
| test_addr | input | ADDR_W | Byte address checked against the protection level |
| status_byte | output | 8 | Status byte returned on a status read |
| addr_locked | output | 1 | Address under test lies in a locked region |
| sr_write_ok | output | 1 | A status write would be accepted now |

## Verification
The region decode is driven with every level code and probed just inside and just outside each boundary. This catches an off-by-one region size or a wrong choice between the sector-granular and block-granular ranges. Level codes in which L4:L3 are nonzero alongside a nonzero L2..L0 show whether the don't-care bits leak into the result. The gating checks separate four conditions: WP low with the enable set, WP low with the enable clear, WP falling before chip select rises and WP falling after it rises. Only the first and third should block the status write.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    LVL_NONE = 3'd0,
    LVL_64   = 3'd1,
    LVL_32   = 3'd2,
    LVL_16   = 3'd3,
    LVL_8    = 3'd4,
    LVL_4    = 3'd5,
    LVL_2    = 3'd6,
    LVL_ALL  = 3'd7
  } prot_lvl_e;

  localparam int unsigned NV_W  = 6;
  localparam int unsigned LVL_W = 5;
  localparam int unsigned TOP_N = 6;

  // number of top address bits that must all be one for a locked address
  function automatic int unsigned lvl_top_bits(prot_lvl_e lvl);
    case (lvl)
      LVL_64:  lvl_top_bits = 6;
      LVL_32:  lvl_top_bits = 5;
      LVL_16:  lvl_top_bits = 4;
      LVL_8:   lvl_top_bits = 3;
      LVL_4:   lvl_top_bits = 2;
      LVL_2:   lvl_top_bits = 1;
      default: lvl_top_bits = 0;
    endcase
  endfunction

endpackage

// File: rtl/flash_wp_level_dec.sv
module flash_wp_level_dec
  import flash_wp_pkg::*;
(
  input  logic [LVL_W-1:0] lvl_bits,
  output prot_lvl_e        lvl
);

  logic [1:0] fine;
  logic [2:0] coarse;

  assign fine   = lvl_bits[4:3];
  assign coarse = lvl_bits[2:0];

  always_comb begin
    lvl = LVL_NONE;
    if (coarse[2]) begin
      lvl = LVL_ALL;
    end else if (coarse != 3'b000) begin
      case (coarse[1:0])
        2'b01:   lvl = LVL_8;
        2'b10:   lvl = LVL_4;
        default: lvl = LVL_2;
      endcase
    end else begin
      case (fine)
        2'b01:   lvl = LVL_64;
        2'b10:   lvl = LVL_32;
        2'b11:   lvl = LVL_16;
        default: lvl = LVL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/flash_wp_region_cmp.sv
module flash_wp_region_cmp
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr,
  input  prot_lvl_e         lvl,
  output logic              locked
);

  localparam int unsigned N_CMP = TOP_N;

  // top_ones[k] is set when the k upper address bits are all one
  logic [N_CMP:0] top_ones;

  assign top_ones[0] = 1'b1;

  generate
    for (genvar k = 1; k <= N_CMP; k++) begin : g_top
      assign top_ones[k] = &addr[ADDR_W-1 -: k];
    end
  endgenerate

  always_comb begin
    case (lvl)
      LVL_NONE: locked = 1'b0;
      LVL_ALL:  locked = 1'b1;
      default:  locked = top_ones[lvl_top_bits(lvl)];
    endcase
  end

endmodule

// File: rtl/flash_wp_regs.sv
module flash_wp_regs
  import flash_wp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            hw_prot,
  input  logic            busy,
  input  logic            cycle_done,
  input  logic            wren_stb,
  input  logic            wrdi_stb,
  input  logic            wrsr_stb,
  input  logic [NV_W-1:0] wrsr_bits,
  output logic            wen_q,
  output logic [NV_W-1:0] nv_q
);

  logic            wen_d;
  logic            wen_en;
  logic [NV_W-1:0] nv_d;
  logic            nv_en;
  logic [NV_W-1:0] stage_q;
  logic [NV_W-1:0] stage_d;
  logic            stage_en;
  logic            pend_q;
  logic            pend_d;
  logic            cs_q;
  logic            cs_rise;
  logic            accept;

  assign cs_rise = cs_n & ~cs_q;
  assign accept  = wrsr_stb & ~busy & wen_q & ~hw_prot;

  // write-enable latch next state
  always_comb begin
    wen_d  = wen_q;
    wen_en = 1'b0;
    if (cycle_done) begin
      wen_d  = 1'b0;
      wen_en = 1'b1;
    end else if (!busy && wrdi_stb) begin
      wen_d  = 1'b0;
      wen_en = 1'b1;
    end else if (!busy && wren_stb) begin
      wen_d  = 1'b1;
      wen_en = 1'b1;
    end
  end

  // pending status write and commit
  always_comb begin
    pend_d   = pend_q;
    stage_d  = stage_q;
    stage_en = 1'b0;
    nv_d     = nv_q;
    nv_en    = 1'b0;
    if (pend_q && hw_prot) begin
      pend_d = 1'b0;
    end else if (pend_q && cs_rise) begin
      pend_d = 1'b0;
      nv_d   = stage_q;
      nv_en  = 1'b1;
    end
    if (accept) begin
      pend_d   = 1'b1;
      stage_d  = wrsr_bits;
      stage_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q   <= 1'b0;
      pend_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      if (wen_en) wen_q <= wen_d;
      pend_q <= pend_d;
      cs_q   <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q    <= '0;
      stage_q <= '0;
    end else begin
      if (nv_en)    nv_q    <= nv_d;
      if (stage_en) stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/flash_wp_status.sv
module flash_wp_status
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              wrsr_stb,
  input  logic [7:0]        wrsr_data,
  input  logic              busy,
  input  logic              cycle_done,
  input  logic [ADDR_W-1:0] test_addr,
  output logic [7:0]        status_byte,
  output logic              addr_locked,
  output logic              sr_write_ok
);

  localparam int unsigned PEN_BIT = NV_W - 1;

  logic            rst_s1_q;
  logic            rst_sync_n;
  logic            wen_q;
  logic [NV_W-1:0] nv_q;
  logic            hw_prot;
  prot_lvl_e       lvl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  assign hw_prot = ~wp_n & nv_q[PEN_BIT];

  flash_wp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs_n       (cs_n),
    .hw_prot    (hw_prot),
    .busy       (busy),
    .cycle_done (cycle_done),
    .wren_stb   (wren_stb),
    .wrdi_stb   (wrdi_stb),
    .wrsr_stb   (wrsr_stb),
    .wrsr_bits  (wrsr_data[7:2]),
    .wen_q      (wen_q),
    .nv_q       (nv_q)
  );

  flash_wp_level_dec u_lvl (
    .lvl_bits (nv_q[LVL_W-1:0]),
    .lvl      (lvl)
  );

  flash_wp_region_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr   (test_addr),
    .lvl    (lvl),
    .locked (addr_locked)
  );

  assign status_byte = busy ? 8'hFF : {nv_q, wen_q, 1'b0};
  assign sr_write_ok = wen_q & ~hw_prot;

endmodule

// File: rtl/flash_wp_status_chk.sv
module flash_wp_status_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       wp_n,
  input logic       busy,
  input logic       cycle_done,
  input logic       wrdi_stb,
  input logic       wen_q,
  input logic [5:0] nv_q,
  input logic [7:0] status_byte,
  input logic       addr_locked,
  input logic       sr_write_ok
);

  // R5
  busy_ones_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> status_byte == 8'hFF);

  // R6
  done_clears_wen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cycle_done |=> !wen_q);

  // R3
  wrdi_clears_wen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wrdi_stb && !busy) |=> !wen_q);

  // R9
  hw_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wp_n && nv_q[5]) |-> !sr_write_ok);

  // R9
  hw_hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wp_n && nv_q[5]) |=> $stable(nv_q));

  // R12
  no_wen_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wen_q |-> !sr_write_ok);

  // R8
  whole_array_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nv_q[2] |-> addr_locked);

endmodule

bind flash_wp_status flash_wp_status_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .wp_n        (wp_n),
  .busy        (busy),
  .cycle_done  (cycle_done),
  .wrdi_stb    (wrdi_stb),
  .wen_q       (wen_q),
  .nv_q        (nv_q),
  .status_byte (status_byte),
  .addr_locked (addr_locked),
  .sr_write_ok (sr_write_ok)
);

// File: tb/flash_wp_status_tb.sv
module flash_wp_status_tb;

  localparam int unsigned ADDR_W = 19;
  localparam int unsigned NVEC   = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n;
  logic              wp_n;
  logic              wren_stb;
  logic              wrdi_stb;
  logic              wrsr_stb;
  logic [7:0]        wrsr_data;
  logic              busy;
  logic              cycle_done;
  logic [ADDR_W-1:0] test_addr;
  logic [7:0]        status_byte;
  logic              addr_locked;
  logic              sr_write_ok;

  int n_chk = 0;
  int n_err = 0;

  // {level L4..L0, address, expected lock}
  localparam logic [24:0] VEC [NVEC] = '{
    {5'b00000, 19'h7FFFF, 1'b0},
    {5'b01000, 19'h7E000, 1'b1},
    {5'b01000, 19'h7DFFF, 1'b0},
    {5'b10000, 19'h7C000, 1'b1},
    {5'b10000, 19'h7BFFF, 1'b0},
    {5'b11000, 19'h78000, 1'b1},
    {5'b11000, 19'h77FFF, 1'b0},
    {5'b00001, 19'h70000, 1'b1},
    {5'b00001, 19'h6FFFF, 1'b0},
    {5'b00010, 19'h60000, 1'b1},
    {5'b00010, 19'h5FFFF, 1'b0},
    {5'b00011, 19'h40000, 1'b1},
    {5'b00011, 19'h3FFFF, 1'b0},
    {5'b00100, 19'h00000, 1'b1},
    {5'b11001, 19'h6FFFF, 1'b0},
    {5'b11100, 19'h00000, 1'b1}
  };

  always #10 clk = ~clk;

  flash_wp_status #(.ADDR_W(ADDR_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wp_n        (wp_n),
    .wren_stb    (wren_stb),
    .wrdi_stb    (wrdi_stb),
    .wrsr_stb    (wrsr_stb),
    .wrsr_data   (wrsr_data),
    .busy        (busy),
    .cycle_done  (cycle_done),
    .test_addr   (test_addr),
    .status_byte (status_byte),
    .addr_locked (addr_locked),
    .sr_write_ok (sr_write_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_wren();
    wren_stb = 1'b1;
    @(negedge clk);
    wren_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_wrdi();
    wrdi_stb = 1'b1;
    @(negedge clk);
    wrdi_stb = 1'b0;
    @(negedge clk);
  endtask

  // status-write frame; optionally drop WP before chip select rises
  task automatic sr_frame(input logic [7:0] d, input logic drop_wp);
    cs_n      = 1'b0;
    wrsr_stb  = 1'b1;
    wrsr_data = d;
    @(negedge clk);
    wrsr_stb = 1'b0;
    if (drop_wp) wp_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_cycle();
    busy = 1'b1;
    @(negedge clk);
    cycle_done = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0;
    busy       = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_level(input logic [7:0] d);
    send_wren();
    sr_frame(d, 1'b0);
    finish_cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1;
    wren_stb = 1'b0; wrdi_stb = 1'b0; wrsr_stb = 1'b0; wrsr_data = '0;
    busy = 1'b0; cycle_done = 1'b0; test_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1
    check("R1 status", status_byte, 8'h00);
    check("R1 sr_write_ok", sr_write_ok, 1'b0);

    // R12: status write without enable is ignored
    sr_frame(8'hFC, 1'b0);
    check("R12 status", status_byte, 8'h00);

    // R2
    send_wren();
    check("R2 wen bit", status_byte, 8'h02);
    check("R12 ok with wen", sr_write_ok, 1'b1);

    // R3 with WP low
    wp_n = 1'b0;
    send_wrdi();
    check("R3 wrdi", status_byte, 8'h00);
    wp_n = 1'b1;

    // R4: bits 1..0 of the data ignored
    send_wren();
    sr_frame(8'h4B, 1'b0);
    check("R4 commit", status_byte, 8'h4A);

    // R5, R6
    busy = 1'b1;
    @(negedge clk);
    check("R5 busy ones", status_byte, 8'hFF);
    cycle_done = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0;
    busy       = 1'b0;
    @(negedge clk);
    check("R6 wen cleared", status_byte, 8'h48);

    // R13: strobes during busy ignored
    busy = 1'b1;
    wren_stb = 1'b1;
    @(negedge clk);
    wren_stb = 1'b0;
    busy = 1'b0;
    @(negedge clk);
    check("R13 wren ignored", status_byte, 8'h48);

    // R7, R8: table walk
    for (int i = 0; i < NVEC; i++) begin
      set_level({1'b0, VEC[i][24:20], 2'b00});
      test_addr = VEC[i][19:1];
      @(negedge clk);
      check((VEC[i][22:20] == 3'b000) ? "R7 region" : "R8 region",
            addr_locked, VEC[i][0]);
    end

    // R9: hardware protection
    set_level(8'h80);
    wp_n = 1'b0;
    send_wren();
    check("R9 ok blocked", sr_write_ok, 1'b0);
    sr_frame(8'h00, 1'b0);
    check("R9 bits held", status_byte, 8'h82);
    wp_n = 1'b1;
    @(negedge clk);
    check("R9 ok released", sr_write_ok, 1'b1);

    // R11: WP drop before chip select rises aborts
    sr_frame(8'h10, 1'b1);
    check("R11 aborted", status_byte, 8'h82);
    wp_n = 1'b1;
    @(negedge clk);
    // R11: WP drop after commit has no effect
    sr_frame(8'h10, 1'b0);
    wp_n = 1'b0;
    @(negedge clk);
    check("R11 committed", status_byte, 8'h12);
    finish_cycle();

    // R10: WP low with enable clear
    send_wren();
    check("R10 ok", sr_write_ok, 1'b1);
    sr_frame(8'h0C, 1'b0);
    check("R10 written", status_byte, 8'h0E);
    finish_cycle();
    wp_n = 1'b1;

    // R1 reset again clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 re-reset", status_byte, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule